// File: doc/BRIEF.md
# Transmit Descriptor Ring Sequencer

This block is the control engine for the transmit half of a descriptor-ring DMA. Software builds a ring of two-word descriptors in host memory and hands each one over by setting its ownership bit. After a start command the sequencer walks the ring. For each descriptor it reads both words and checks ownership. It then reads the frame words one at a time and pushes them into a transmit FIFO. It waits for the MAC to signal that the frame has left the wire, and finally writes the first descriptor word back with ownership returned to software.

If a descriptor is still owned by software, the sequencer parks in a suspended state until a poll-demand command tells it to look again. A stop command never cuts a frame in half: it is held until the current descriptor has been closed. The current phase is always visible as a 3-bit code with fixed values. Completion, missing-descriptor and stop events each come out as one-cycle pulses.

The memory request port and the FIFO push port are valid/ready streams. Once `mem_req_valid` or `fifo_valid` is raised, the address, write flag and data on that port stay frozen until the matching ready is seen high at a clock edge; the consumer may hold ready low for any number of cycles. Read data returns on `mem_rsp_valid` with no ready, because the sequencer never has more than one read outstanding.

Top module: `txd_seq`

## Requirements
- R1: `state_code` uses only these values: 000 stopped, 001 fetching a descriptor, 011 moving frame data, 010 waiting for end of transmission, 111 closing the descriptor, 110 suspended. Codes 100 and 101 never appear, and reset leaves the block in 000 with every request, push and event output low.
- R2: In 000 the block stays put until `cmd_start`. Start resets the ring index to 0 and enters 001. Descriptor n sits at word address `ring_base + 2*n`: its first word is read, then its second word. In the first word, bit DATA_W-1 is the ownership flag (1 = owned by the DMA) and bits LEN_W-1:0 give the frame length in words. The second word holds the buffer word address.
- R3: A fetched first word with ownership flag 0 moves the block to 110 and pulses `evt_buf_unavail` for one cycle. The block stays in 110 until `cmd_poll`, which returns it to 001 and re-reads the same descriptor.
- R4: In 011 the block reads words `buf + 0` … `buf + len-1` in order and pushes each one to the FIFO. `fifo_last` is high only with the final word. A length of zero moves no data and goes straight from 001 to 111.
- R5: After the final word is accepted the block holds 010 until `mac_tx_done`. A pulse on `mac_tx_done` in any other state has no effect.
- R6: In 111 the block writes the first descriptor word back to its own address with the ownership flag cleared and the length unchanged. On acceptance it pulses `evt_tx_done`, advances the ring index modulo RING_DEPTH, and returns to 001.
- R7: `cmd_stop` while running is remembered and takes effect when the current close is accepted: the block enters 000 instead of 001 and pulses `evt_stopped`. In 110 a stop takes effect at once, also with `evt_stopped`. A stop in 000 produces no pulse.
- R8: While `mem_req_valid` is high and `mem_req_ready` is low, the request valid, address, write flag and write data hold steady. While `fifo_valid` is high and `fifo_ready` is low, the FIFO valid, data and last flag hold steady.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_start | input | 1 | Start pulse, honoured in stopped state |
| cmd_stop | input | 1 | Stop pulse, applied at the next frame boundary |
| cmd_poll | input | 1 | Poll-demand pulse, honoured in suspended state |
| ring_base | input | ADDR_W | Word address of descriptor 0 |
| mem_req_valid | output | 1 | Memory request valid |
| mem_req_ready | input | 1 | Memory request accepted |
| mem_req_write | output | 1 | 1 = write, 0 = read |
| mem_req_addr | output | ADDR_W | Request word address |
| mem_req_wdata | output | DATA_W | Write data |
| mem_rsp_valid | input | 1 | Read data valid |
| mem_rsp_data | input | DATA_W | Read data |
| fifo_valid | output | 1 | Frame word valid |
| fifo_ready | input | 1 | FIFO accepts the word |
| fifo_data | output | DATA_W | Frame word |
| fifo_last | output | 1 | Final word of the frame |
| mac_tx_done | input | 1 | MAC reports the frame has been sent |
| state_code | output | 3 | Current state code |
| evt_tx_done | output | 1 | One-cycle pulse after a descriptor is closed |
| evt_buf_unavail | output | 1 | One-cycle pulse on a descriptor not owned by the DMA |
| evt_stopped | output | 1 | One-cycle pulse on entry to stopped from any other state |

## Verification
The properties assume that the memory returns exactly one `mem_rsp_valid` per accepted read, no earlier than the cycle after acceptance, and never otherwise. They also assume that commands are single-cycle pulses. The bench memory model keeps to this by answering every accepted read exactly one cycle later. The FIFO sink and the request port apply several fixed back-pressure patterns, and the bench drives `mac_tx_done` only as a clean pulse, apart from deliberate stray pulses while frame data is moving.

// File: rtl/txd_pkg.sv
package txd_pkg;

  typedef enum logic [2:0] {
    ST_STOP  = 3'b000,
    ST_FETCH = 3'b001,
    ST_WAIT  = 3'b010,
    ST_DATA  = 3'b011,
    ST_SUSP  = 3'b110,
    ST_CLOSE = 3'b111
  } txd_state_e;

  typedef enum logic [1:0] {
    PH_REQ  = 2'd0,
    PH_RSP  = 2'd1,
    PH_PUSH = 2'd2
  } txd_phase_e;

  localparam int DESC_WORDS = 2;

endpackage

// File: rtl/txd_ring_ptr.sv
module txd_ring_ptr #(
  parameter int ADDR_W     = 16,
  parameter int RING_DEPTH = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clear,
  input  logic              advance,
  input  logic [ADDR_W-1:0] ring_base,
  output logic [ADDR_W-1:0] desc_addr
);
  localparam int IDX_W = (RING_DEPTH > 2) ? $clog2(RING_DEPTH) : 1;
  localparam logic [IDX_W-1:0] IDX_MAX = IDX_W'(RING_DEPTH - 1);

  logic [IDX_W-1:0] idx_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      idx_q <= '0;
    end else if (clear) begin
      idx_q <= '0;
    end else if (advance) begin
      idx_q <= (idx_q == IDX_MAX) ? '0 : idx_q + 1'b1;
    end
  end

  assign desc_addr = ring_base + ADDR_W'(idx_q) * ADDR_W'(txd_pkg::DESC_WORDS);

endmodule

// File: rtl/txd_beat_ctr.sv
module txd_beat_ctr #(
  parameter int LEN_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clear,
  input  logic             inc,
  input  logic [LEN_W-1:0] len,
  output logic [LEN_W-1:0] beat,
  output logic             is_last
);
  logic [LEN_W-1:0] beat_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      beat_q <= '0;
    end else if (clear) begin
      beat_q <= '0;
    end else if (inc) begin
      beat_q <= beat_q + 1'b1;
    end
  end

  assign beat    = beat_q;
  assign is_last = (beat_q == len - 1'b1);

endmodule

// File: rtl/txd_seq.sv
module txd_seq #(
  parameter int ADDR_W     = 16,
  parameter int DATA_W     = 32,
  parameter int LEN_W      = 8,
  parameter int RING_DEPTH = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cmd_start,
  input  logic              cmd_stop,
  input  logic              cmd_poll,
  input  logic [ADDR_W-1:0] ring_base,
  output logic              mem_req_valid,
  input  logic              mem_req_ready,
  output logic              mem_req_write,
  output logic [ADDR_W-1:0] mem_req_addr,
  output logic [DATA_W-1:0] mem_req_wdata,
  input  logic              mem_rsp_valid,
  input  logic [DATA_W-1:0] mem_rsp_data,
  output logic              fifo_valid,
  input  logic              fifo_ready,
  output logic [DATA_W-1:0] fifo_data,
  output logic              fifo_last,
  input  logic              mac_tx_done,
  output logic [2:0]        state_code,
  output logic              evt_tx_done,
  output logic              evt_buf_unavail,
  output logic              evt_stopped
);
  import txd_pkg::*;

  localparam int OWN_BIT = DATA_W - 1;

  txd_state_e        state_q;
  txd_phase_e        phase_q;
  logic              word_sel_q;
  logic [DATA_W-1:0] word0_q;
  logic [ADDR_W-1:0] buf_q;
  logic [DATA_W-1:0] data_q;
  logic              stop_pend_q;
  logic              evt_done_q, evt_unav_q, evt_stop_q;

  logic [ADDR_W-1:0] desc_addr;
  logic [LEN_W-1:0]  beat;
  logic              is_last;
  logic [LEN_W-1:0]  frame_len;
  logic              ptr_clear, ptr_adv, beat_clear, beat_inc;
  logic              close_acc, push_acc, word1_rsp;

  assign frame_len = word0_q[LEN_W-1:0];
  assign close_acc = (state_q == ST_CLOSE) && mem_req_ready;
  assign push_acc  = (state_q == ST_DATA) && (phase_q == PH_PUSH) && fifo_ready;
  assign word1_rsp = (state_q == ST_FETCH) && (phase_q == PH_RSP) && mem_rsp_valid && word_sel_q;

  assign ptr_clear  = (state_q == ST_STOP) && cmd_start;
  assign ptr_adv    = close_acc;
  assign beat_clear = word1_rsp;
  assign beat_inc   = push_acc && !is_last;

  txd_ring_ptr #(.ADDR_W(ADDR_W), .RING_DEPTH(RING_DEPTH)) u_ptr (
    .clk       (clk),
    .rst_n     (rst_n),
    .clear     (ptr_clear),
    .advance   (ptr_adv),
    .ring_base (ring_base),
    .desc_addr (desc_addr)
  );

  txd_beat_ctr #(.LEN_W(LEN_W)) u_beat (
    .clk     (clk),
    .rst_n   (rst_n),
    .clear   (beat_clear),
    .inc     (beat_inc),
    .len     (frame_len),
    .beat    (beat),
    .is_last (is_last)
  );

  // request and push ports
  always_comb begin
    mem_req_valid = 1'b0;
    mem_req_write = 1'b0;
    mem_req_addr  = desc_addr;
    mem_req_wdata = {1'b0, word0_q[DATA_W-2:0]};
    case (state_q)
      ST_FETCH: begin
        mem_req_valid = (phase_q == PH_REQ);
        mem_req_addr  = desc_addr + ADDR_W'(word_sel_q);
      end
      ST_DATA: begin
        mem_req_valid = (phase_q == PH_REQ);
        mem_req_addr  = buf_q + ADDR_W'(beat);
      end
      ST_CLOSE: begin
        mem_req_valid = 1'b1;
        mem_req_write = 1'b1;
      end
      default: ;
    endcase
  end

  assign fifo_valid = (state_q == ST_DATA) && (phase_q == PH_PUSH);
  assign fifo_data  = data_q;
  assign fifo_last  = is_last;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q     <= ST_STOP;
      phase_q     <= PH_REQ;
      word_sel_q  <= 1'b0;
      word0_q     <= '0;
      buf_q       <= '0;
      data_q      <= '0;
      stop_pend_q <= 1'b0;
      evt_done_q  <= 1'b0;
      evt_unav_q  <= 1'b0;
      evt_stop_q  <= 1'b0;
    end else begin
      evt_done_q <= 1'b0;
      evt_unav_q <= 1'b0;
      evt_stop_q <= 1'b0;
      if (cmd_stop && state_q != ST_STOP) stop_pend_q <= 1'b1;
      case (state_q)
        ST_STOP: begin
          stop_pend_q <= 1'b0;
          if (cmd_start) begin
            state_q    <= ST_FETCH;
            phase_q    <= PH_REQ;
            word_sel_q <= 1'b0;
          end
        end
        ST_FETCH: begin
          case (phase_q)
            PH_REQ: if (mem_req_ready) phase_q <= PH_RSP;
            PH_RSP: if (mem_rsp_valid) begin
              if (!word_sel_q) begin
                word0_q <= mem_rsp_data;
                if (!mem_rsp_data[OWN_BIT]) begin
                  state_q    <= ST_SUSP;
                  evt_unav_q <= 1'b1;
                end else begin
                  word_sel_q <= 1'b1;
                  phase_q    <= PH_REQ;
                end
              end else begin
                buf_q   <= mem_rsp_data[ADDR_W-1:0];
                phase_q <= PH_REQ;
                state_q <= (frame_len == '0) ? ST_CLOSE : ST_DATA;
              end
            end
            default: phase_q <= PH_REQ;
          endcase
        end
        ST_DATA: begin
          case (phase_q)
            PH_REQ: if (mem_req_ready) phase_q <= PH_RSP;
            PH_RSP: if (mem_rsp_valid) begin
              data_q  <= mem_rsp_data;
              phase_q <= PH_PUSH;
            end
            default: if (fifo_ready) begin
              phase_q <= PH_REQ;
              if (is_last) state_q <= ST_WAIT;
            end
          endcase
        end
        ST_WAIT: begin
          if (mac_tx_done) begin
            state_q <= ST_CLOSE;
            phase_q <= PH_REQ;
          end
        end
        ST_CLOSE: begin
          if (mem_req_ready) begin
            evt_done_q <= 1'b1;
            if (stop_pend_q || cmd_stop) begin
              state_q    <= ST_STOP;
              evt_stop_q <= 1'b1;
            end else begin
              state_q    <= ST_FETCH;
              phase_q    <= PH_REQ;
              word_sel_q <= 1'b0;
            end
          end
        end
        ST_SUSP: begin
          if (stop_pend_q || cmd_stop) begin
            state_q    <= ST_STOP;
            evt_stop_q <= 1'b1;
          end else if (cmd_poll) begin
            state_q    <= ST_FETCH;
            phase_q    <= PH_REQ;
            word_sel_q <= 1'b0;
          end
        end
        default: state_q <= ST_STOP;
      endcase
    end
  end

  assign state_code      = state_q;
  assign evt_tx_done     = evt_done_q;
  assign evt_buf_unavail = evt_unav_q;
  assign evt_stopped     = evt_stop_q;

endmodule

// File: rtl/txd_seq_chk.sv
module txd_seq_chk #(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 32
) (
  input logic              clk,
  input logic              rst_n,
  input logic              cmd_start,
  input logic              cmd_stop,
  input logic              cmd_poll,
  input logic              mem_req_valid,
  input logic              mem_req_ready,
  input logic              mem_req_write,
  input logic [ADDR_W-1:0] mem_req_addr,
  input logic [DATA_W-1:0] mem_req_wdata,
  input logic              fifo_valid,
  input logic              fifo_ready,
  input logic [DATA_W-1:0] fifo_data,
  input logic              fifo_last,
  input logic              mac_tx_done,
  input logic [2:0]        state_code,
  input logic              evt_tx_done,
  input logic              evt_buf_unavail,
  input logic              evt_stopped
);

  AST_NO_RSVD_CODE: assert property (@(posedge clk) disable iff (!rst_n)
    state_code != 3'b100 && state_code != 3'b101); // R1

  AST_STOP_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (state_code == 3'b000 && !cmd_start) |=> state_code == 3'b000); // R2

  AST_UNAVAIL_SUSP: assert property (@(posedge clk) disable iff (!rst_n)
    evt_buf_unavail |-> (state_code == 3'b110 && $past(state_code) == 3'b001)); // R3

  AST_SUSP_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (state_code == 3'b110 && !cmd_poll && !cmd_stop) |=> state_code == 3'b110); // R3

  AST_LAST_TO_WAIT: assert property (@(posedge clk) disable iff (!rst_n)
    (fifo_valid && fifo_ready && fifo_last) |=> state_code == 3'b010); // R4

  AST_WAIT_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (state_code == 3'b010 && !mac_tx_done) |=> state_code == 3'b010); // R5

  AST_DONE_AFTER_CLOSE: assert property (@(posedge clk) disable iff (!rst_n)
    evt_tx_done |-> $past(state_code) == 3'b111); // R6

  AST_STOP_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    evt_stopped |-> (state_code == 3'b000 && $past(state_code) != 3'b000)); // R7

  AST_REQ_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req_valid && !mem_req_ready) |=> (mem_req_valid && $stable(mem_req_addr)
      && $stable(mem_req_write) && $stable(mem_req_wdata))); // R8

  AST_FIFO_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
    (fifo_valid && !fifo_ready) |=> (fifo_valid && $stable(fifo_data)
      && $stable(fifo_last))); // R8

endmodule

bind txd_seq txd_seq_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_chk (
  .clk             (clk),
  .rst_n           (rst_n),
  .cmd_start       (cmd_start),
  .cmd_stop        (cmd_stop),
  .cmd_poll        (cmd_poll),
  .mem_req_valid   (mem_req_valid),
  .mem_req_ready   (mem_req_ready),
  .mem_req_write   (mem_req_write),
  .mem_req_addr    (mem_req_addr),
  .mem_req_wdata   (mem_req_wdata),
  .fifo_valid      (fifo_valid),
  .fifo_ready      (fifo_ready),
  .fifo_data       (fifo_data),
  .fifo_last       (fifo_last),
  .mac_tx_done     (mac_tx_done),
  .state_code      (state_code),
  .evt_tx_done     (evt_tx_done),
  .evt_buf_unavail (evt_buf_unavail),
  .evt_stopped     (evt_stopped)
);

// File: tb/tb_txd_seq.sv
module tb_txd_seq;
  localparam int ADDR_W = 16;
  localparam int DATA_W = 32;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic              cmd_start = 1'b0, cmd_stop = 1'b0, cmd_poll = 1'b0;
  logic [ADDR_W-1:0] ring_base = 16'h0010;
  logic              mem_req_valid, mem_req_write;
  logic              mem_req_ready = 1'b0;
  logic [ADDR_W-1:0] mem_req_addr;
  logic [DATA_W-1:0] mem_req_wdata;
  logic              mem_rsp_valid = 1'b0;
  logic [DATA_W-1:0] mem_rsp_data = '0;
  logic              fifo_valid, fifo_last;
  logic              fifo_ready = 1'b0;
  logic [DATA_W-1:0] fifo_data;
  logic              mac_tx_done = 1'b0;
  logic [2:0]        state_code;
  logic              evt_tx_done, evt_buf_unavail, evt_stopped;

  always #10 clk = ~clk;

  txd_seq dut (
    .clk(clk), .rst_n(rst_n), .cmd_start(cmd_start), .cmd_stop(cmd_stop),
    .cmd_poll(cmd_poll), .ring_base(ring_base),
    .mem_req_valid(mem_req_valid), .mem_req_ready(mem_req_ready),
    .mem_req_write(mem_req_write), .mem_req_addr(mem_req_addr),
    .mem_req_wdata(mem_req_wdata), .mem_rsp_valid(mem_rsp_valid),
    .mem_rsp_data(mem_rsp_data), .fifo_valid(fifo_valid),
    .fifo_ready(fifo_ready), .fifo_data(fifo_data), .fifo_last(fifo_last),
    .mac_tx_done(mac_tx_done), .state_code(state_code),
    .evt_tx_done(evt_tx_done), .evt_buf_unavail(evt_buf_unavail),
    .evt_stopped(evt_stopped)
  );

  int total = 0, bad = 0, cyc = 0;
  int bp = 0;
  logic [31:0] mem [0:255];
  logic [31:0] got_data [0:255];
  logic        got_last [0:255];
  int          got_n = 0;
  logic [15:0] rd_log [0:255];
  int          rd_n = 0;
  int n_done = 0, n_unav = 0, n_stop = 0;
  int rsvd_seen = 0, early_exit = 0, hold_viol = 0;
  bit rd_pend = 0;
  logic [15:0] rd_addr = '0;
  int wait_cnt = 0;
  logic [2:0] prev_st = 3'b000;
  bit mac_prev = 0, req_hold = 0, fifo_hold = 0, done_flag = 0;
  logic [15:0] held_addr = '0;
  logic [31:0] held_fdata = '0;

  function automatic bit rdy(int sel, int c);
    case (sel)
      0: return 1'b1;
      1: return (c % 2) == 1;
      2: return (c % 3) == 0;
      default: return ((c / 2) % 2) == 1;
    endcase
  endfunction

  function automatic logic [31:0] dval(int b, int i, int k);
    return 32'h5A00_0000 + 32'(b * 4096 + i * 256 + k);
  endfunction

  task automatic chk(bit ok, string req, string what, longint act, longint exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  // memory model, FIFO sink, MAC model and monitors
  always @(negedge clk) begin
    cyc++;
    if (cyc > 150000 && !done_flag) begin
      done_flag = 1;
      total++; bad++;
      $display("FAIL watchdog: actual=%0d expected=%0d", cyc, 150000);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
    if (rst_n) begin
      if (state_code == 3'b100 || state_code == 3'b101) rsvd_seen++;
      if (prev_st == 3'b010 && state_code != 3'b010 && !mac_prev) early_exit++;
      if (req_hold && !(mem_req_valid && mem_req_addr == held_addr)) hold_viol++;
      if (fifo_hold && !(fifo_valid && fifo_data == held_fdata)) hold_viol++;
      if (evt_tx_done) n_done++;
      if (evt_buf_unavail) n_unav++;
      if (evt_stopped) n_stop++;
    end
    prev_st = state_code;
    if (rd_pend) begin
      mem_rsp_valid = 1'b1;
      mem_rsp_data  = mem[rd_addr[7:0]];
      rd_pend = 0;
    end else begin
      mem_rsp_valid = 1'b0;
    end
    mem_req_ready = rdy(bp, cyc);
    req_hold  = mem_req_valid && !mem_req_ready;
    held_addr = mem_req_addr;
    if (mem_req_valid && mem_req_ready && rst_n) begin
      if (mem_req_write) begin
        mem[mem_req_addr[7:0]] = mem_req_wdata;
      end else begin
        rd_pend = 1;
        rd_addr = mem_req_addr;
        rd_log[rd_n % 256] = mem_req_addr;
        rd_n++;
      end
    end
    fifo_ready = rdy(3 - bp, cyc);
    fifo_hold  = fifo_valid && !fifo_ready;
    held_fdata = fifo_data;
    if (fifo_valid && fifo_ready && rst_n) begin
      got_data[got_n % 256] = fifo_data;
      got_last[got_n % 256] = fifo_last;
      got_n++;
    end
    if (state_code == 3'b010) wait_cnt++; else wait_cnt = 0;
    mac_tx_done = (state_code == 3'b010 && wait_cnt == 3) ||
                  (state_code == 3'b011 && (cyc % 5) == 0);
    mac_prev = mac_tx_done;
  end

  task automatic tick(int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk); #1;
    end
  endtask

  task automatic pulse_start(); @(negedge clk); #1 cmd_start = 1; @(negedge clk); #1 cmd_start = 0; endtask
  task automatic pulse_stop();  @(negedge clk); #1 cmd_stop  = 1; @(negedge clk); #1 cmd_stop  = 0; endtask
  task automatic pulse_poll();  @(negedge clk); #1 cmd_poll  = 1; @(negedge clk); #1 cmd_poll  = 0; endtask

  task automatic wait_state(logic [2:0] code, string req);
    int n = 0;
    while (state_code != code && n < 5000) begin
      @(negedge clk); #1; n++;
    end
    chk(state_code == code, req, "reach state", state_code, code);
  endtask

  task automatic setup_ring(logic [15:0] base, int b);
    for (int a = 0; a < 256; a++) mem[a] = 32'hDEAD_0000 + 32'(a);
    for (int i = 0; i < 4; i++) begin
      mem[8'(base + 16'(2 * i))]     = {1'b1, 23'd0, 8'((i + b) % 5)};
      mem[8'(base + 16'(2 * i + 1))] = 32'h40 + 32'(i * 16);
      for (int k = 0; k < 16; k++) mem[8'(32'h40 + 32'(i * 16 + k))] = dval(b, i, k);
    end
  endtask

  int d0, u0, s0, idx, ln;
  logic [15:0] bases [0:1];

  initial begin
    bases[0] = 16'h0010; bases[1] = 16'h0020;
    for (int a = 0; a < 256; a++) mem[a] = '0;
    // reset state (R1)
    tick(3);
    chk(state_code == 3'b000, "R1", "state in reset", state_code, 0);
    chk(!mem_req_valid && !fifo_valid, "R1", "idle ports in reset", {mem_req_valid, fifo_valid}, 0);
    rst_n = 1'b1;
    tick(3);
    chk(state_code == 3'b000, "R1", "state after reset", state_code, 0);
    chk(!evt_tx_done && !evt_buf_unavail && !evt_stopped, "R1", "events after reset",
        {evt_tx_done, evt_buf_unavail, evt_stopped}, 0);
    chk(state_code == 3'b000, "R2", "no start keeps stopped", state_code, 0);

    // sweep: ring bases x back-pressure patterns x lengths 0..4
    for (int bi = 0; bi < 2; bi++) begin
      for (int b = 0; b < 4; b++) begin
        bp = b;
        ring_base = bases[bi];
        setup_ring(ring_base, b);
        got_n = 0; rd_n = 0;
        d0 = n_done; u0 = n_unav; s0 = n_stop;
        pulse_start();
        wait_state(3'b110, "R3");
        chk(rd_log[0] == ring_base, "R2", "first descriptor read", rd_log[0], ring_base);
        chk(rd_log[1] == ring_base + 16'd1, "R2", "second word read", rd_log[1], ring_base + 16'd1);
        chk(rd_log[(rd_n - 1) % 256] == ring_base, "R6", "wrap to descriptor 0",
            rd_log[(rd_n - 1) % 256], ring_base);
        chk(n_done - d0 == 4, "R6", "close pulses", n_done - d0, 4);
        chk(n_unav - u0 == 1, "R3", "unavailable pulse", n_unav - u0, 1);
        idx = 0;
        for (int i = 0; i < 4; i++) begin
          ln = (i + b) % 5;
          chk(mem[8'(ring_base + 16'(2 * i))] == {1'b0, 23'd0, 8'(ln)}, "R6", "write-back word",
              mem[8'(ring_base + 16'(2 * i))], {1'b0, 23'd0, 8'(ln)});
          for (int k = 0; k < ln; k++) begin
            chk(got_data[idx] == dval(b, i, k), "R4", "frame word", got_data[idx], dval(b, i, k));
            chk(got_last[idx] == (k == ln - 1), "R4", "last flag", got_last[idx], (k == ln - 1));
            idx++;
          end
        end
        chk(got_n == idx, "R4", "word count", got_n, idx);
        pulse_stop();
        tick(2);
        chk(state_code == 3'b000, "R7", "stop from suspend", state_code, 0);
        chk(n_stop - s0 == 1, "R7", "stop pulse", n_stop - s0, 1);
      end
    end

    // poll demand re-reads the descriptor
    bp = 0; ring_base = 16'h0010;
    setup_ring(ring_base, 0);
    pulse_start();
    wait_state(3'b110, "R3");
    mem[8'h10] = {1'b1, 23'd0, 8'd3};
    for (int k = 0; k < 3; k++) mem[8'(32'h40 + 32'(k))] = dval(7, 0, k);
    got_n = 0; rd_n = 0;
    d0 = n_done; u0 = n_unav;
    tick(4);
    chk(state_code == 3'b110 && rd_n == 0, "R3", "no fetch without poll", rd_n, 0);
    pulse_poll();
    wait_state(3'b110, "R3");
    chk(rd_log[0] == 16'h0010, "R3", "poll re-reads same descriptor", rd_log[0], 16'h0010);
    chk(got_n == 3, "R3", "polled frame words", got_n, 3);
    for (int k = 0; k < 3; k++)
      chk(got_data[k] == dval(7, 0, k), "R4", "polled word", got_data[k], dval(7, 0, k));
    chk(n_done - d0 == 1, "R6", "polled close", n_done - d0, 1);
    chk(n_unav - u0 == 1, "R3", "next not owned", n_unav - u0, 1);
    chk(rd_log[(rd_n - 1) % 256] == 16'h0012, "R6", "index advanced", rd_log[(rd_n - 1) % 256], 16'h0012);
    pulse_stop();
    tick(2);

    // stop while running waits for the frame boundary
    bp = 1;
    setup_ring(ring_base, 1);
    got_n = 0;
    d0 = n_done; s0 = n_stop;
    pulse_start();
    wait_state(3'b011, "R4");
    pulse_stop();
    wait_state(3'b000, "R7");
    chk(n_done - d0 == 1, "R7", "frame finished before stop", n_done - d0, 1);
    chk(n_stop - s0 == 1, "R7", "stop pulse when running", n_stop - s0, 1);
    chk(got_n == 1, "R7", "frame words before stop", got_n, 1);
    chk(mem[8'h12][31] == 1'b1, "R7", "next descriptor untouched", mem[8'h12][31], 1);
    pulse_stop();
    tick(5);
    chk(n_stop - s0 == 1, "R7", "stop while stopped has no pulse", n_stop - s0, 1);
    chk(state_code == 3'b000, "R7", "still stopped", state_code, 0);

    chk(rsvd_seen == 0, "R1", "reserved code seen", rsvd_seen, 0);
    chk(early_exit == 0, "R5", "left wait without MAC done", early_exit, 0);
    chk(hold_viol == 0, "R8", "port changed while stalled", hold_viol, 0);

    done_flag = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule